// File: doc/BRIEF.md
# Timer Tick Prescaler and Channel Divider

This block turns one base clock into a set of per-channel tick enables for a multi-channel PWM timer (five channels by default). Two 8-bit prescalers divide the base rate; the lower channels share the first prescaler and the remaining channels share the second. Each channel then applies its own power-of-two divider to its group's prescaled strobe. Instead of the divider, a channel can follow an external timer strobe belonging to its group. The downstream channel counters advance only in cycles where their tick enable is high.

Configuration goes through a small register port with two words. Word 0 holds both prescaler values. Word 1 holds one 4-bit selector per channel. A selector code whose bit is set in the `EXT_MASK` parameter routes the external strobe to the channel. Any other code picks a divider exponent. The external strobes are assumed to be single-cycle pulses that are already synchronous to the base clock.

Top module: `timer_tick_gen`

## Requirements
- R1: After reset both configuration words read as zero, and with that configuration every channel's tick enable is high in every cycle (period 1).
- R2: Word 0 (`cfg_addr`=0) holds prescaler 0 in bits [7:0] and prescaler 1 in bits [15:8]. It reads back what was written, and bits [31:16] read as zero.
- R3: Word 1 (`cfg_addr`=1) holds channel k's 4-bit selector in bits [4k+3:4k]. It reads back what was written, and bits [31:20] read as zero.
- R4: A prescaler value P produces one group strobe every P+1 base cycles. Channels 0 and 1 use prescaler 0, and channels 2 to 4 use prescaler 1.
- R5: A selector code n from 0 to 3 that is not in `EXT_MASK` gives a tick period of (P+1)·2^(n+`DIV_BASE`) cycles. Codes 4 to 15 that are not in `EXT_MASK` behave like code 3.
- R6: A code whose bit is set in `EXT_MASK` (default: codes 5, 6 and 7) makes the channel's tick equal to its group's external strobe one cycle later: `ext_tick[0]` for channels 0 and 1, `ext_tick[1]` for channels 2 to 4. The prescaler value has no effect on such a channel.
- R7: A new prescaler value takes effect only when the prescaler next reloads. The interval already in progress completes with the old value.
- R8: A tick on a divider-fed channel follows a prescaler strobe of its own group by exactly one cycle, so each tick lasts one cycle whenever the period is greater than one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low reset; clears all configuration |
| cfg_we | input | 1 | Write strobe for the configuration word at `cfg_addr` |
| cfg_addr | input | 1 | Word select: 0 for the prescalers, 1 for the channel selectors |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected word (combinational) |
| ext_tick | input | 2 | External strobes: bit 0 for the lower group, bit 1 for the upper group |
| tick_en | output | 5 | Per-channel single-cycle tick enables |

## Verification
The bound checker checks several rules on every cycle. The prescaler counters step down by one between reloads and load the programmed value at zero. Every divider tick follows a strobe of its group. Every externally fed channel copies its group's strobe one cycle late. Word 0 reads back its last write. The actual tick periods for different prescaler values and codes, the clamping of large codes, the grouping of channels and the deferred prescaler change can only be shown by the bench's scenarios, which measure the intervals between ticks at the ports.

// File: rtl/tick_pkg.sv
package tick_pkg;
   localparam int NUM_GRP      = 2;
   localparam int DIV_CODE_MAX = 3;   // four power-of-two steps

   function automatic int grp_of(input int ch, input int grp0_ch);
      return (ch < grp0_ch) ? 0 : 1;
   endfunction
endpackage

// File: rtl/tick_cfg_regs.sv
module tick_cfg_regs #(
   parameter int NUM_CH = 5,
   parameter int PRE_W  = 8,
   parameter int MUX_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               we,
   input  logic                               addr,
   input  logic [DATA_W-1:0]                  wdata,
   output logic [DATA_W-1:0]                  rdata,
   output logic [tick_pkg::NUM_GRP-1:0][PRE_W-1:0] pre_val,
   output logic [NUM_CH-1:0][MUX_W-1:0]       mux_code
);
   localparam int W0_BITS = tick_pkg::NUM_GRP * PRE_W;
   localparam int W1_BITS = NUM_CH * MUX_W;

   if (W0_BITS > DATA_W) begin : g_bad_w0
      $error("prescaler fields do not fit in one word");
   end
   if (W1_BITS > DATA_W) begin : g_bad_w1
      $error("selector fields do not fit in one word");
   end

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_val  <= '0;
         mux_code <= '0;
      end else if (we) begin
         if (!addr) begin
            for (int g = 0; g < tick_pkg::NUM_GRP; g++)
               pre_val[g] <= wdata[g*PRE_W +: PRE_W];
         end else begin
            for (int c = 0; c < NUM_CH; c++)
               mux_code[c] <= wdata[c*MUX_W +: MUX_W];
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (!addr) rdata[W0_BITS-1:0] = pre_val;
      else       rdata[W1_BITS-1:0] = mux_code;
   end
endmodule

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
   parameter int PRE_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PRE_W-1:0] reload_val,
   output logic             strobe,
   output logic [PRE_W-1:0] cnt
);
   if (PRE_W < 1) begin : g_bad_w
      $error("prescaler width must be at least one");
   end

   assign strobe = (cnt == '0);

   // reload only at zero: a new value never cuts the running interval
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt <= '0;
      else if (strobe) cnt <= reload_val;
      else             cnt <= cnt - PRE_W'(1);
   end
endmodule

// File: rtl/tick_chan_sel.sv
module tick_chan_sel #(
   parameter int              MUX_W    = 4,
   parameter int              DIV_BASE = 0,
   parameter logic [(1<<MUX_W)-1:0] EXT_MASK = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pre_stb,
   input  logic             ext_stb,
   input  logic [MUX_W-1:0] code,
   output logic             ext_sel,
   output logic             tick
);
   localparam int MAX_EXP = tick_pkg::DIV_CODE_MAX + DIV_BASE;
   localparam int CW      = MAX_EXP;

   logic [CW-1:0] dcnt;
   logic [1:0]    step;
   logic [2:0]    expo;
   logic [CW-1:0] low_mask;
   logic          div_hit;
   logic          tick_d;

   assign ext_sel  = EXT_MASK[code];
   assign step     = (code > MUX_W'(tick_pkg::DIV_CODE_MAX)) ? 2'd3 : code[1:0];
   assign expo     = 3'(step) + 3'(DIV_BASE);
   assign low_mask = CW'((32'd1 << expo) - 32'd1);
   assign div_hit  = &(dcnt | ~low_mask);
   assign tick_d   = ext_sel ? ext_stb : (pre_stb & div_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt <= '0;
         tick <= 1'b0;
      end else begin
         if (pre_stb) dcnt <= dcnt + CW'(1);
         tick <= tick_d;
      end
   end
endmodule

// File: rtl/timer_tick_gen.sv
module timer_tick_gen #(
   parameter int    NUM_CH   = 5,
   parameter int    GRP0_CH  = 2,
   parameter int    PRE_W    = 8,
   parameter int    MUX_W    = 4,
   parameter int    DATA_W   = 32,
   parameter int    DIV_BASE = 0,
   parameter logic [(1<<MUX_W)-1:0] EXT_MASK = 16'h00E0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic              cfg_addr,
   input  logic [DATA_W-1:0] cfg_wdata,
   output logic [DATA_W-1:0] cfg_rdata,
   input  logic [1:0]        ext_tick,
   output logic [NUM_CH-1:0] tick_en
);
   import tick_pkg::*;

   if (DIV_BASE != 0 && DIV_BASE != 1) begin : g_bad_base
      $error("DIV_BASE must be 0 or 1");
   end
   if (GRP0_CH < 1 || GRP0_CH >= NUM_CH) begin : g_bad_grp
      $error("GRP0_CH must leave both groups non-empty");
   end
   if (MUX_W < 2) begin : g_bad_mux
      $error("selector must be at least two bits");
   end

   logic [NUM_GRP-1:0][PRE_W-1:0] pre_val;
   logic [NUM_GRP-1:0][PRE_W-1:0] pre_cnt;
   logic [NUM_GRP-1:0]            pre_stb;
   logic [NUM_CH-1:0][MUX_W-1:0]  mux_code;
   logic [NUM_CH-1:0]             ext_sel;

   tick_cfg_regs #(
      .NUM_CH(NUM_CH), .PRE_W(PRE_W), .MUX_W(MUX_W), .DATA_W(DATA_W)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata),
      .pre_val(pre_val), .mux_code(mux_code)
   );

   for (genvar g = 0; g < NUM_GRP; g++) begin : g_pre
      tick_prescaler #(.PRE_W(PRE_W)) u_pre (
         .clk(clk), .rst_n(rst_n), .reload_val(pre_val[g]),
         .strobe(pre_stb[g]), .cnt(pre_cnt[g])
      );
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int GRP = grp_of(c, GRP0_CH);
      tick_chan_sel #(
         .MUX_W(MUX_W), .DIV_BASE(DIV_BASE), .EXT_MASK(EXT_MASK)
      ) u_sel (
         .clk(clk), .rst_n(rst_n),
         .pre_stb(pre_stb[GRP]), .ext_stb(ext_tick[GRP]),
         .code(mux_code[c]), .ext_sel(ext_sel[c]), .tick(tick_en[c])
      );
   end
endmodule

// File: rtl/timer_tick_gen_chk.sv
module timer_tick_gen_chk #(
   parameter int NUM_CH  = 5,
   parameter int GRP0_CH = 2,
   parameter int PRE_W   = 8,
   parameter int DATA_W  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_we,
   input logic              cfg_addr,
   input logic [DATA_W-1:0] cfg_wdata,
   input logic [DATA_W-1:0] cfg_rdata,
   input logic [1:0]        ext_tick,
   input logic [NUM_CH-1:0] tick_en,
   input logic [1:0][PRE_W-1:0] pre_cnt,
   input logic [1:0][PRE_W-1:0] pre_val,
   input logic [1:0]        pre_stb,
   input logic [NUM_CH-1:0] ext_sel
);
   // R2: word 0 returns the last value written to it
   a_r2_word0_readback: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !cfg_addr) |=>
         (cfg_addr || cfg_rdata[2*PRE_W-1:0] == $past(cfg_wdata[2*PRE_W-1:0])));

   for (genvar g = 0; g < 2; g++) begin : g_grp
      // R7: the running interval is never shortened
      a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
         (pre_cnt[g] != '0) |=> (pre_cnt[g] == $past(pre_cnt[g]) - PRE_W'(1)));
      // R4/R7: reload picks up the programmed value
      a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
         (pre_cnt[g] == '0) |=> (pre_cnt[g] == $past(pre_val[g])));
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      localparam int GRP = tick_pkg::grp_of(c, GRP0_CH);
      // R8: divider ticks follow a strobe of the channel's own group
      a_r8_tick_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
         (tick_en[c] && !$past(ext_sel[c])) |-> $past(pre_stb[GRP]));
      // R6: external selection copies the group strobe one cycle late
      a_r6_ext_follow: assert property (@(posedge clk) disable iff (!rst_n)
         $past(ext_sel[c]) |-> (tick_en[c] == $past(ext_tick[GRP])));
   end
endmodule

bind timer_tick_gen timer_tick_gen_chk #(
   .NUM_CH(NUM_CH), .GRP0_CH(GRP0_CH), .PRE_W(PRE_W), .DATA_W(DATA_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
   .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ext_tick(ext_tick),
   .tick_en(tick_en), .pre_cnt(pre_cnt), .pre_val(pre_val),
   .pre_stb(pre_stb), .ext_sel(ext_sel)
);

// File: tb/timer_tick_gen_test.sv
module timer_tick_gen_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic        cfg_addr = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [1:0]  ext_tick = '0;
   logic [4:0]  tick_en;

   int checks = 0;
   int errors = 0;
   bit done = 0;
   logic [31:0] w0 = '0, w1 = '0;

   typedef struct { int ch; int exp; string req; } item_t;
   item_t exp_q[$];

   always #4 clk = ~clk;   // 125 MHz

   timer_tick_gen uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .ext_tick(ext_tick), .tick_en(tick_en)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic set_pre(input int g, input int v);
      w0[g*8 +: 8] = 8'(v);
      wr(1'b0, w0);
   endtask

   task automatic set_code(input int c, input int code);
      w1[c*4 +: 4] = 4'(code);
      wr(1'b1, w1);
   endtask

   task automatic rd(input logic a, output logic [31:0] d);
      @(negedge clk);
      cfg_addr = a;
      #1 d = cfg_rdata;
   endtask

   task automatic wait_tick(input int ch);
      do @(negedge clk); while (!tick_en[ch]);
   endtask

   task automatic interval(input int ch, output int n);
      n = 0;
      do begin @(negedge clk); n++; end while (!tick_en[ch]);
   endtask

   // driver side of the scoreboard
   task automatic expect_period(input int ch, input int exp, input string req);
      item_t it;
      it.ch = ch; it.exp = exp; it.req = req;
      exp_q.push_back(it);
      wait (exp_q.size() == 0);
   endtask

   // monitor: pops expectations and measures the tick interval
   initial begin
      forever begin
         item_t it;
         int n;
         wait (exp_q.size() != 0);
         it = exp_q[0];
         wait_tick(it.ch);
         wait_tick(it.ch);
         interval(it.ch, n);
         chk(n == it.exp, it.req, n, it.exp);
         void'(exp_q.pop_front());
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      rd(1'b0, d); chk(d == 0, "R1 word0 after reset", int'(d), 0);
      rd(1'b1, d); chk(d == 0, "R1 word1 after reset", int'(d), 0);
      expect_period(2, 1, "R1 ch2 period with zero config");

      // R2, R3: layout and unused upper bits
      wr(1'b0, 32'hFFFF_FFFF);
      rd(1'b0, d); chk(d == 32'h0000_FFFF, "R2 word0 readback", int'(d), 32'hFFFF);
      wr(1'b0, 32'h0000_A53C);
      rd(1'b0, d); chk(d == 32'h0000_A53C, "R2 word0 fields", int'(d), 32'hA53C);
      wr(1'b1, 32'hFFFF_FFFF);
      rd(1'b1, d); chk(d == 32'h000F_FFFF, "R3 word1 readback", int'(d), 32'hFFFFF);
      wr(1'b1, 32'h0004_3210);
      rd(1'b1, d); chk(d == 32'h0004_3210, "R3 word1 fields", int'(d), 32'h43210);
      w0 = '0; w1 = '0;
      wr(1'b0, w0); wr(1'b1, w1);

      // R4, R5: prescaled and divided periods, per group
      set_pre(0, 3);
      expect_period(0, 4, "R4 ch0 P=3 code0");
      set_code(1, 2);
      expect_period(1, 16, "R5 ch1 P=3 code2");
      set_pre(1, 1);
      set_code(2, 1);
      expect_period(2, 4, "R4 ch2 uses prescaler 1");
      set_code(3, 3);
      expect_period(3, 16, "R5 ch3 P=1 code3");
      set_code(4, 4);
      expect_period(4, 16, "R5 ch4 code4 clamps to code3");
      set_code(4, 15);
      expect_period(4, 16, "R5 ch4 code15 clamps to code3");
      expect_period(0, 4, "R4 ch0 unaffected by prescaler 1");
      set_pre(1, 255);
      expect_period(4, 2048, "R5 ch4 P=255 code3");
      set_pre(0, 255);
      expect_period(0, 256, "R4 ch0 P=255");

      // R7: change takes effect only at the next reload
      set_pre(0, 7);
      expect_period(0, 8, "R7 settled P=7");
      wait_tick(0);
      w0[7:0] = 8'd1;
      cfg_we = 1'b1; cfg_addr = 1'b0; cfg_wdata = w0;
      n = 0;
      do begin
         @(negedge clk); n++;
         if (n == 1) cfg_we = 1'b0;
      end while (!tick_en[0]);
      chk(n == 8, "R7 running interval keeps old value", n, 8);
      interval(0, n);
      chk(n == 2, "R7 next interval uses new value", n, 2);

      // R6: external strobes, prescaler irrelevant
      set_pre(0, 255);
      set_code(0, 5);
      set_code(3, 6);
      set_code(2, 7);
      for (int i = 0; i < 24; i++) begin
         logic [1:0] e;
         e = {1'(i % 3 == 0), 1'(i % 2 == 1)};
         ext_tick = e;
         @(negedge clk);
         chk(tick_en[0] == e[0], "R6 ch0 follows ext0", int'(tick_en[0]), int'(e[0]));
         chk(tick_en[3] == e[1], "R6 ch3 follows ext1", int'(tick_en[3]), int'(e[1]));
         chk(tick_en[2] == e[1], "R6 ch2 follows ext1", int'(tick_en[2]), int'(e[1]));
      end
      ext_tick = '0;
      @(negedge clk);
      @(negedge clk);
      chk(tick_en[0] == 1'b0, "R6 ch0 quiet without ext0", int'(tick_en[0]), 0);

      // R8: single-cycle tick at period > 1
      set_pre(1, 2);
      set_code(3, 0);
      wait_tick(3);
      @(negedge clk);
      chk(tick_en[3] == 1'b0, "R8 tick lasts one cycle", int'(tick_en[3]), 0);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule